// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Gate Sequencer

This block turns a single PWM request into two gate-enable outputs for a synchronous buck half-bridge, one for the high-side switch and one for the low-side switch. A gate is never switched on on a timer alone. The sequencer first waits until a comparator reports that the opposite gate has actually dropped below its turn-off threshold. It then adds a fixed, parameterised margin before it enables the new gate. Each comparator input passes through a two-flop synchronizer before the sequencer uses it.

Two overrides take priority over the PWM request. The shutdown input has the highest priority and holds both gates off, which leaves the output floating. The forced low-side input, driven by over-voltage protection, keeps the high-side gate off and drives the low-side gate through the normal dead-time sequence. A wait can stall because a monitor stays high. If the stall lasts for a programmable number of cycles, the sequencer raises a stuck-gate flag and keeps the opposing gate off. If the request reverses in the middle of a wait, the sequencer abandons that wait and sequences toward the new target, with a fresh delay count.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: While reset is low at a clock edge, both gate enables and the stuck flag are 0 after that edge, and both synchronized monitors read 1 (gate assumed on).
- R2: The high-side and low-side gate enables are never 1 in the same cycle.
- R3: The high-side enable rises only after the synchronized low-side monitor has read 0 at DLY_CYCLES consecutive edges during the wait toward the high side. A 1 on that monitor restarts the count.
- R4: The low-side enable rises only after the synchronized high-side monitor has read 0 at DLY_CYCLES consecutive edges during the wait toward the low side. A 1 on that monitor restarts the count.
- R5: When shutdown is 1 at an edge, both enables are 0 after that edge, whatever the other inputs are.
- R6: When force_ls is 1 (and shutdown is 0), the high-side enable is 0 after the next edge, and the low side is sequenced on even while pwm_req is 1.
- R7: Each raw monitor input reaches the sequencer through two flops, so a change on a raw monitor affects the gate sequencing two edges later.
- R8: After STUCK_LIMIT consecutive edges during one wait at which the opposing synchronized monitor reads 1, stuck_flag is 1 and both enables stay 0. The flag clears at the first edge at which that stall condition is absent.
- R9: If the target changes during a wait, the delay count restarts for the new target and no gate is enabled early. A high-side rise always follows an edge at which pwm_req was 1.
- R10: A gate enable drops at the first edge at which its gate is no longer the target. The target is off when shutdown=1, low side when force_ls=1, high side when pwm_req=1, and low side otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_req | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| shutdown | input | 1 | Holds both gates off (highest priority) |
| force_ls | input | 1 | Over-voltage request: low side on, high side off |
| hs_mon_raw | input | 1 | Asynchronous comparator: high-side gate still above its off threshold |
| ls_mon_raw | input | 1 | Asynchronous comparator: low-side gate still above its off threshold |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| stuck_flag | output | 1 | A wait has been stalled by a monitor for STUCK_LIMIT cycles |

## Verification
The hardest situation to reach from the ports is a monitor that falls and then rises again partway through the margin count, or a request that reverses inside a wait. Either one must land within a window of a few cycles that lies behind the two-flop synchronizer. The bench drives the monitors from a plant model that follows each gate enable with a programmable fall lag. On top of that it injects single-cycle glitches and random request reversals, so that many waits are cut or restarted at different offsets. A cycle-accurate reference model judges every cycle. Separate phases hold one monitor stuck high for longer than the stall limit and then release it.

// File: rtl/hbseq_pkg.sv
// Package: shared types for the half-bridge gate sequencer.
// Assumes: sequencing target and state fit in two bits each.
package hbseq_pkg;

    // Which gate the sequencer is trying to turn on.
    typedef enum logic [1:0] {
        GOAL_OFF = 2'd0,
        GOAL_HS  = 2'd1,
        GOAL_LS  = 2'd2
    } goal_t;

    // Sequencer state: a gate conducting, both off, or waiting on dead time.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HS   = 2'd1,
        ST_LS   = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/hbseq_sync.sv
// Module: multi-stage synchronizer for asynchronous comparator inputs.
// Assumes: STAGES >= 1; reset value chosen by the parent (gate assumed on).
module hbseq_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // One flop stage when only a single stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
                else        chain[0] <= d;
            end
        end else begin : g_multi
            // Shift the sample down the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{ {WIDTH{RST_VAL}} }};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hbseq_target.sv
// Module: priority decode of the override and PWM inputs into a gate target.
// Assumes: inputs are synchronous to the sequencer clock.
module hbseq_target
    import hbseq_pkg::*;
(
    input  logic  shutdown,
    input  logic  force_ls,
    input  logic  pwm_req,
    output goal_t target
);

    // Shutdown beats forced low side, which beats the PWM request.
    always_comb begin
        if (shutdown)      target = GOAL_OFF;
        else if (force_ls) target = GOAL_LS;
        else if (pwm_req)  target = GOAL_HS;
        else               target = GOAL_LS;
    end

endmodule

// File: rtl/hbseq_stall_timer.sv
// Module: counts consecutive stalled wait cycles and flags a stuck gate.
// Assumes: LIMIT >= 1; the count saturates at LIMIT.
module hbseq_stall_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic stuck
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count stalled edges, clear on any edge without a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!stall)             cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end

    assign stuck = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/hbseq_fsm.sv
// Module: dead-time state machine. It drops the conducting gate at once,
// waits for the opposite synchronized monitor to read low for DLY
// consecutive edges, and only then enables the new gate.
// Assumes: DLY covers synchronizer latency plus comparator response, so a
// stale low monitor cannot release a gate early; DLY >= 1.
module hbseq_fsm
    import hbseq_pkg::*;
#(
    parameter int DLY = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  goal_t target,
    input  logic  hs_mon_s,
    input  logic  ls_mon_s,
    output logic  hs_en,
    output logic  ls_en,
    output logic  stall
);

    localparam int CW = $clog2(DLY + 1);

    seq_state_t    state_q, state_d;
    goal_t         goal_q, goal_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          opp_mon;

    // Monitor of the gate that must be off before the goal gate rises.
    assign opp_mon = (goal_q == GOAL_HS) ? ls_mon_s : hs_mon_s;

    // Wait is blocked by the opposite gate still being seen on.
    assign stall = (state_q == ST_WAIT) && (target == goal_q) && opp_mon;

    // Next-state logic for the gate sequence.
    always_comb begin
        state_d = state_q;
        goal_d  = goal_q;
        cnt_d   = cnt_q;
        if (target == GOAL_OFF) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_HS: if (target != GOAL_HS) begin
                    state_d = ST_WAIT;
                    goal_d  = target;
                    cnt_d   = '0;
                end
                ST_LS: if (target != GOAL_LS) begin
                    state_d = ST_WAIT;
                    goal_d  = target;
                    cnt_d   = '0;
                end
                ST_OFF: begin
                    state_d = ST_WAIT;
                    goal_d  = target;
                    cnt_d   = '0;
                end
                ST_WAIT: begin
                    if (target != goal_q) begin
                        goal_d = target;
                        cnt_d  = '0;
                    end else if (opp_mon) begin
                        cnt_d = '0;
                    end else if (cnt_q == CW'(DLY - 1)) begin
                        state_d = (goal_q == GOAL_HS) ? ST_HS : ST_LS;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State, goal and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            goal_q  <= GOAL_LS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            goal_q  <= goal_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered gate enables decoded from the next state (glitch-free outputs).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= (state_d == ST_HS);
            ls_en <= (state_d == ST_LS);
        end
    end

endmodule

// File: rtl/halfbridge_gate_seq.sv
// Module: top of the adaptive dead-time gate sequencer.
// Assumes: pwm_req, shutdown and force_ls are synchronous to clk; the two
// monitor inputs are asynchronous and are synchronized here.
module halfbridge_gate_seq
    import hbseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_CYCLES  = 5,
    parameter int STUCK_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic shutdown,
    input  logic force_ls,
    input  logic hs_mon_raw,
    input  logic ls_mon_raw,
    output logic hs_gate_en,
    output logic ls_gate_en,
    output logic stuck_flag
);

    logic  hs_mon_s, ls_mon_s;
    logic  stall;
    goal_t target;

    hbseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hs_mon_raw, ls_mon_raw}),
        .q     ({hs_mon_s, ls_mon_s})
    );

    hbseq_target u_target (
        .shutdown (shutdown),
        .force_ls (force_ls),
        .pwm_req  (pwm_req),
        .target   (target)
    );

    hbseq_fsm #(.DLY(DLY_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .target   (target),
        .hs_mon_s (hs_mon_s),
        .ls_mon_s (ls_mon_s),
        .hs_en    (hs_gate_en),
        .ls_en    (ls_gate_en),
        .stall    (stall)
    );

    hbseq_stall_timer #(.LIMIT(STUCK_LIMIT)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .stall (stall),
        .stuck (stuck_flag)
    );

endmodule

// File: rtl/halfbridge_gate_seq_chk.sv
// Module: property checker bound to the gate sequencer top.
// Assumes: synchronous active-low reset; all checks disabled in reset.
module halfbridge_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_req,
    input logic shutdown,
    input logic force_ls,
    input logic hs_mon_s,
    input logic ls_mon_s,
    input logic hs_gate_en,
    input logic ls_gate_en,
    input logic stuck_flag
);

    // R2: never both gates on
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_en && ls_gate_en));

    // R3: high side rises only with low side off and its monitor low
    a_r3_hs_after_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_en) |-> ($past(!ls_mon_s) && $past(!ls_gate_en)));

    // R4: low side rises only with high side off and its monitor low
    a_r4_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_en) |-> ($past(!hs_mon_s) && $past(!hs_gate_en)));

    // R5: shutdown forces both gates off at the next edge
    a_r5_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!hs_gate_en && !ls_gate_en));

    // R6: forced low side keeps the high side off
    a_r6_force_blocks_hs: assert property (@(posedge clk) disable iff (!rst_n)
        force_ls |=> !hs_gate_en);

    // R8: a stuck wait leaves both gates off
    a_r8_stuck_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_flag |-> (!hs_gate_en && !ls_gate_en));

    // R9: high side rises only after a cycle that requested it
    a_r9_hs_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_en) |-> $past(pwm_req));

    // R10: high side drops at the edge after its request goes away
    a_r10_hs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_req |=> !hs_gate_en);

    // R10: low side drops at the edge after the high side is requested
    a_r10_ls_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_req && !force_ls && !shutdown) |=> !ls_gate_en);

endmodule

bind halfbridge_gate_seq halfbridge_gate_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_req    (pwm_req),
    .shutdown   (shutdown),
    .force_ls   (force_ls),
    .hs_mon_s   (hs_mon_s),
    .ls_mon_s   (ls_mon_s),
    .hs_gate_en (hs_gate_en),
    .ls_gate_en (ls_gate_en),
    .stuck_flag (stuck_flag)
);

// File: tb/halfbridge_gate_seq_bench.sv
// Bench: behavioural reference model compared every cycle, a gate plant
// model that drives the monitors, directed phases and a random phase.
module halfbridge_gate_seq_bench;

    localparam int DLY   = 5;
    localparam int LIMIT = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0, shutdown = 1'b0, force_ls = 1'b0;
    logic hs_mon_raw = 1'b0, ls_mon_raw = 1'b0;
    logic hs_gate_en, ls_gate_en, stuck_flag;

    always #4 clk = ~clk;   // 125 MHz

    halfbridge_gate_seq #(.SYNC_STAGES(2), .DLY_CYCLES(DLY), .STUCK_LIMIT(LIMIT))
    u_halfbridge_gate_seq (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .shutdown(shutdown),
        .force_ls(force_ls), .hs_mon_raw(hs_mon_raw), .ls_mon_raw(ls_mon_raw),
        .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en), .stuck_flag(stuck_flag)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model: 0 off, 1 high on, 2 low on, 3 waiting; goal 1 hi / 2 lo.
    int m_st = 0, m_goal = 2, m_cnt = 0, m_stall = 0;
    bit hs_q[$] = '{1'b1, 1'b1};
    bit ls_q[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        int tgt;
        bit opp;
        if (!rst_n) begin
            m_st = 0; m_goal = 2; m_cnt = 0; m_stall = 0;
            hs_q = '{1'b1, 1'b1};
            ls_q = '{1'b1, 1'b1};
        end else begin
            tgt = shutdown ? 0 : (force_ls ? 2 : (pwm_req ? 1 : 2));
            opp = (m_goal == 1) ? ls_q[1] : hs_q[1];
            if (m_st == 3 && tgt == m_goal && opp)
                m_stall = (m_stall < LIMIT) ? m_stall + 1 : LIMIT;
            else
                m_stall = 0;
            if (tgt == 0) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0 || (m_st != 3 && m_st != tgt)) begin
                m_st = 3; m_goal = tgt; m_cnt = 0;
            end else if (m_st == 3) begin
                if (tgt != m_goal) begin
                    m_goal = tgt; m_cnt = 0;
                end else if (opp) m_cnt = 0;
                else if (m_cnt == DLY - 1) begin
                    m_st = m_goal; m_cnt = 0;
                end else m_cnt++;
            end
            hs_q = '{hs_mon_raw, hs_q[0]};
            ls_q = '{ls_mon_raw, ls_q[0]};
        end
    end

    // Gate plant: monitor stays high for a lag after the enable drops.
    int hs_lag = 0, ls_lag = 0, lag = 3;
    bit hs_stuck = 1'b0, ls_stuck = 1'b0, glitch_en = 1'b0;

    task automatic plant();
        if (hs_gate_en) hs_lag = lag; else if (hs_lag > 0) hs_lag--;
        if (ls_gate_en) ls_lag = lag; else if (ls_lag > 0) ls_lag--;
        hs_mon_raw = hs_stuck | hs_gate_en | (hs_lag > 0);
        ls_mon_raw = ls_stuck | ls_gate_en | (ls_lag > 0);
        if (glitch_en && $urandom_range(0, 15) == 0) hs_mon_raw = ~hs_mon_raw;
        if (glitch_en && $urandom_range(0, 15) == 0) ls_mon_raw = ~ls_mon_raw;
    endtask

    // Compare every output against the model, and check overlap on its own.
    task automatic compare();
        bit e_hs, e_ls, e_st;
        e_hs = (m_st == 1); e_ls = (m_st == 2); e_st = (m_stall == LIMIT);
        vectors++;
        if (hs_gate_en !== e_hs || ls_gate_en !== e_ls || stuck_flag !== e_st) begin
            miscompares++;
            $display("FAIL %s: hs/ls/stuck actual %b%b%b expected %b%b%b at %0t",
                     cur_req, hs_gate_en, ls_gate_en, stuck_flag, e_hs, e_ls, e_st, $time);
        end
        vectors++;
        if (hs_gate_en === 1'b1 && ls_gate_en === 1'b1) begin
            miscompares++;
            $display("FAIL R2: both gates on, actual 11 expected not 11 at %0t", $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            plant();
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still prints the summary.
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cur_req = "R1"; step(4);
        rst_n = 1'b1;
        cur_req = "R3"; pwm_req = 1'b1; step(30);
        cur_req = "R4"; pwm_req = 1'b0; step(30);
        cur_req = "R10";
        for (int k = 0; k < 6; k++) begin pwm_req = ~pwm_req; step(20); end
        cur_req = "R9"; lag = 6;
        for (int k = 0; k < 8; k++) begin pwm_req = ~pwm_req; step(2 + k); end
        step(30);
        lag = 3;
        cur_req = "R6"; pwm_req = 1'b1; step(25); force_ls = 1'b1; step(30);
        force_ls = 1'b0; step(25);
        cur_req = "R5"; shutdown = 1'b1;
        for (int k = 0; k < 10; k++) begin pwm_req = ~pwm_req; step(3); end
        shutdown = 1'b0; step(30);
        cur_req = "R8"; pwm_req = 1'b0; step(25);
        ls_stuck = 1'b1; pwm_req = 1'b1; step(LIMIT + 20);
        ls_stuck = 1'b0; step(25);
        hs_stuck = 1'b1; pwm_req = 1'b0; step(LIMIT + 10);
        pwm_req = 1'b1; step(5); pwm_req = 1'b0; step(LIMIT + 5);
        hs_stuck = 1'b0; step(25);
        cur_req = "R7"; glitch_en = 1'b1;
        for (int k = 0; k < 1500; k++) begin
            if ($urandom_range(0, 9) == 0) pwm_req = ~pwm_req;
            step(1);
        end
        cur_req = "R2";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 7) == 0)  pwm_req = ~pwm_req;
            force_ls = ($urandom_range(0, 40) == 0) ? ~force_ls : force_ls;
            shutdown = ($urandom_range(0, 60) == 0) ? ~shutdown : shutdown;
            lag = $urandom_range(0, 6);
            step(1);
        end
        cur_req = "R1"; rst_n = 1'b0; step(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule